// File: doc/BRIEF.md
# Sequential Two's-Complement Shift-Add Multiplier

This block multiplies two N-bit operands over several clock cycles and returns the 2N-bit product. A request is made by raising `start` for one cycle with the multiplicand on `op_a`, the multiplier on `op_b` and `is_signed` choosing between two's-complement and unsigned interpretation. While the block works it holds `busy`. A one-cycle `done` pulse marks the cycle in which `product` first carries the result.

The result is kept in a high/low register pair. The multiplier starts in the low half and the high half starts at zero. In each iteration the least significant bit of the low half decides whether the multiplicand is combined with the high half. That combination goes through an adder one bit wider than the operands. The pair then moves one place to the right, and the adder's top bit enters at the most significant position. In signed mode both adder inputs are sign-extended and the last iteration subtracts instead of adding, which accounts for the negative weight of the multiplier's sign bit. In unsigned mode the inputs are zero-extended, every iteration adds, and the carry-out is shifted in.

Top module: `seq_mul`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy` and `done` are low and `product` is zero.
- R2: When `start` is high and `busy` is low at a rising clock edge, the operands and `is_signed` are captured at that edge, and `busy` is high in the following cycle.
- R3: `done` is high for exactly one cycle. That cycle follows the (N+1)-th rising edge, counting the edge that accepted `start` as the first. `busy` stays high from the cycle after acceptance until `done` rises, and it is low while `done` is high.
- R4: With `is_signed`=1, `product` in the done cycle equals the 2N-bit two's-complement product of `op_a` and `op_b`, for example -4 times -3 gives +12 and -4 times +5 gives -20.
- R5: With `is_signed`=1, the product is correct when either or both operands are the most negative N-bit value, for example (-2^(N-1)) squared gives +2^(2N-2).
- R6: With `is_signed`=0, `product` in the done cycle equals the unsigned 2N-bit product, for example all-ones squared gives 2^(2N) - 2^(N+1) + 1.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running operation finishes at the same cycle and gives the same product as it would without that pulse.
- R8: After `done`, `product` holds its value unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released on the clock |
| start | input | 1 | Request to begin a multiplication; ignored while busy |
| is_signed | input | 1 | 1 selects two's-complement operands, 0 selects unsigned operands |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product is valid from this cycle |
| product | output | 2N | Double-width result, held until the next accepted start |

## Verification
If the edge that accepts `start` is counted as edge 0, `busy` is due in the cycle after edge 0, and `done` and the final `product` are due in the cycle after edge N. Each request in the bench is driven on a falling edge. The bench then steps one falling edge at a time, so its checks sample midway between the edges where each value is due. It checks that `busy` is high and `done` is low during every iteration cycle. It checks `done` and `product` in the cycle after edge N, and it confirms that `done` has dropped and `product` is unchanged one cycle later and after a few further idle cycles. Every product is compared with a bench function that multiplies the sign-extended or zero-extended operands. The operands come from a seeded random stream, with directed corner cases placed among them.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

  // Operation applied by the widened adder in one iteration
  typedef enum logic [1:0] {
    ALU_PASS = 2'b00,
    ALU_ADD  = 2'b01,
    ALU_SUB  = 2'b10
  } alu_op_e;

endpackage

// File: rtl/seq_mul_addsub.sv
module seq_mul_addsub
  import seq_mul_pkg::*;
#(
  parameter int unsigned W = 33
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = lhs_i + rhs_i;
      ALU_SUB: res_o = lhs_i - rhs_i;
      default: res_o = lhs_i;
    endcase
  end

endmodule

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl #(
  parameter int unsigned N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          cnt_en;

  // Decode of the current state
  always_comb begin
    load_o = start_i && !busy_q;
    step_o = busy_q;
    last_o = busy_q && (cnt_q == LAST_CNT);
  end

  // Next state
  always_comb begin
    cnt_en = load_o || busy_q;
    cnt_d  = load_o ? '0 : cnt_q + 1'b1;
    if (load_o) begin
      busy_d = 1'b1;
    end else if (last_o) begin
      busy_d = 1'b0;
    end else begin
      busy_d = busy_q;
    end
    done_d = last_o;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R3
  busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> busy_q);

endmodule

// File: rtl/seq_mul_dp.sv
module seq_mul_dp
  import seq_mul_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  logic           sgn_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] prod_o
);

  localparam int unsigned AW = N + 1;

  logic [N-1:0]  hi_q, hi_d;
  logic [N-1:0]  lo_q, lo_d;
  logic [N-1:0]  mc_q;
  logic          sgn_q;
  logic [AW-1:0] hi_ext, mc_ext, sum;
  alu_op_e       op;
  logic          pair_en;

  // Operand extension and operation select
  always_comb begin
    hi_ext = {sgn_q & hi_q[N-1], hi_q};
    mc_ext = {sgn_q & mc_q[N-1], mc_q};
    if (!lo_q[0]) begin
      op = ALU_PASS;
    end else if (last_i && sgn_q) begin
      op = ALU_SUB;
    end else begin
      op = ALU_ADD;
    end
  end

  seq_mul_addsub #(.W(AW)) alu_i (
    .lhs_i (hi_ext),
    .rhs_i (mc_ext),
    .op_i  (op),
    .res_o (sum)
  );

  // Next value of the product pair
  always_comb begin
    pair_en = load_i || step_i;
    if (load_i) begin
      hi_d = '0;
      lo_d = b_i;
    end else begin
      hi_d = sum[AW-1:1];
      lo_d = {sum[0], lo_q[N-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      mc_q  <= '0;
      sgn_q <= 1'b0;
    end else begin
      if (pair_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      if (load_i) begin
        mc_q  <= a_i;
        sgn_q <= sgn_i;
      end
    end
  end

  assign prod_o = {hi_q, lo_q};

  // R7
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mc_q) && $stable(sgn_q));

endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int unsigned N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       load, step, last;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  seq_mul_ctrl #(.N(N)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy),
    .done_o  (done)
  );

  seq_mul_dp #(.N(N)) dp_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (load),
    .step_i (step),
    .last_i (last),
    .sgn_i  (is_signed),
    .a_i    (op_a),
    .b_i    (op_b),
    .prod_o (product)
  );

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy && done));

  // R3
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> done);

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(start));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !start) |=> $stable(product));

endmodule

// File: tb/seq_mul_tb_top.sv
module seq_mul_tb_top;

  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int N_RANDOM   = 400;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic           is_signed;
  logic [W-1:0]   op_a;
  logic [W-1:0]   op_b;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  seq_mul #(.N(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .op_a      (op_a),
    .op_b      (op_b),
    .busy      (busy),
    .done      (done),
    .product   (product)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic sg);
    logic [2*W-1:0] ea;
    logic [2*W-1:0] eb;
    ea = sg ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = sg ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // One complete multiplication; inject places a start pulse mid-run
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg,
                        input string req, input bit inject);
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b, sg);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; is_signed = sg;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R2", {62'd0, busy, done}, 64'd2);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k < W) begin
        chk(busy === 1'b1 && done === 1'b0, "R3", {62'd0, busy, done}, 64'd2);
        if (inject && k == 2) begin
          start = 1'b1; op_a = ~a; op_b = ~b + 1'b1; is_signed = ~sg;
        end
      end else begin
        chk(done === 1'b1 && busy === 1'b0, "R3", {62'd0, busy, done}, 64'd1);
        chk(product === exp, inject ? "R7" : req, 64'(product), 64'(exp));
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R3", {63'd0, done}, 64'd0);
    chk(product === exp, "R8", 64'(product), 64'(exp));
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_CYCLES && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_CYCLES);
      report();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [2*W-1:0] held;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b1; start = 1'b0; is_signed = 1'b0; op_a = '0; op_b = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1",
        {46'd0, busy, done, product}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after release
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1",
        {46'd0, busy, done, product}, 64'd0);
    repeat (3) @(negedge clk);

    // R4 directed signed cases
    run_op(8'hFC, 8'hFD, 1'b1, "R4", 1'b0);   // -4 * -3
    run_op(8'hFC, 8'h05, 1'b1, "R4", 1'b0);   // -4 * +5
    run_op(8'h05, 8'hFC, 1'b1, "R4", 1'b0);   // +5 * -4
    run_op(8'h7F, 8'h7F, 1'b1, "R4", 1'b0);
    run_op(8'h00, 8'h80, 1'b1, "R4", 1'b0);
    // R5 most negative operands
    run_op(8'h80, 8'h80, 1'b1, "R5", 1'b0);
    run_op(8'h80, 8'h7F, 1'b1, "R5", 1'b0);
    run_op(8'h80, 8'hFF, 1'b1, "R5", 1'b0);
    run_op(8'hFF, 8'h80, 1'b1, "R5", 1'b0);
    // R6 unsigned
    run_op(8'hFF, 8'hFF, 1'b0, "R6", 1'b0);
    run_op(8'h80, 8'h80, 1'b0, "R6", 1'b0);
    run_op(8'hFC, 8'hFD, 1'b0, "R6", 1'b0);
    // R7 start ignored while busy
    run_op(8'hFC, 8'hFD, 1'b1, "R7", 1'b1);
    run_op(8'hC3, 8'h9A, 1'b0, "R7", 1'b1);

    // R8 result held over idle cycles with operands changing
    held = product;
    op_a = 8'h11; op_b = 8'h22; is_signed = 1'b0;
    repeat (5) @(negedge clk);
    chk(product === held && busy === 1'b0 && done === 1'b0, "R8",
        64'(product), 64'(held));

    // Random operands, both modes
    for (int i = 0; i < N_RANDOM; i++) begin
      logic sg;
      ra = W'($urandom);
      rb = W'($urandom);
      sg = 1'($urandom);
      run_op(ra, rb, sg, sg ? "R4" : "R6", (i % 37) == 5);
    end

    finished = 1;
    report();
    $finish;
  end

endmodule